// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one warp-wide memory instruction (an address for every lane plus an active-lane mask) and turns it into the smallest set of cache-line requests that covers the active lanes. Lanes whose addresses share a cache line ride in one request. Each request carries three things: the line-aligned base address, a byte-enable vector for the bytes touched inside that line, and a bit vector that names the lanes it serves. The memory side uses the lane vector to route returned data back to those lanes.

Requests leave one per cycle on a valid/ready stream. The consumer may hold ready low for any number of cycles. While it does, the current request stays on the outputs unchanged and no unserved lane is dropped. The input side is also valid/ready, but it accepts only while the block is idle: after the last request of an instruction, the block raises a one-cycle done pulse carrying the request count. Upstream logic can use that count, or the uncoalesced flag, to tell fully merged accesses from scattered ones.

The line order is fixed. Each step serves the line of the lowest-numbered active lane that has not been served yet. Lanes are assumed to issue naturally aligned accesses of ACCESS_BYTES bytes.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, in_ready is 1, req_valid is 0 and done is 0. in_ready is 1 only when no instruction is in progress, and an instruction is taken on a cycle where in_valid and in_ready are both 1.
- R2: Active lanes whose addresses agree above the low log2(LINE_BYTES) bits (64-byte lines by default) are served by a single request. req_base is that line's address with the low log2(LINE_BYTES) bits zero.
- R3: A lane whose in_mask bit is 0 never appears in req_lanes and never causes a request. An instruction with an all-zero mask produces no request, and done rises in the cycle after acceptance with done_count 0.
- R4: Each request serves the line of the lowest-numbered unserved active lane. Its req_lanes (bit i means lane i) holds exactly the unserved active lanes in that line.
- R5: Bit b of req_bytes is 1 exactly when some lane in req_lanes has in-line offset o with o <= b < o + ACCESS_BYTES. Bytes past the end of the line are dropped.
- R6: While req_valid is 1 and req_ready is 0, req_valid stays 1 and req_base, req_lanes and req_bytes hold their values. No lane is lost.
- R7: done is 1 for exactly one cycle: the cycle after the handshake of the final request. In that cycle done_count equals the number of requests the instruction produced, and in_ready is 1.
- R8: done_uncoalesced is 1 with done when done_count is greater than 1, and 0 otherwise.
- R9: Lanes 0..N-1 at 4-byte addresses 0x0, 0x4, ... with N*4 <= 64 give one request: base 0x0, bytes 0 through 4N-1 enabled (through offset 28..31 for eight lanes), done_count 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A warp instruction is offered |
| in_ready | output | 1 | Block is idle and accepts an instruction |
| in_addr | input | LANES*ADDR_W | Lane addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| in_mask | input | LANES | Active-lane mask, bit i for lane i |
| req_valid | output | 1 | A merged request is presented |
| req_ready | input | 1 | Memory side takes the request |
| req_base | output | ADDR_W | Line-aligned request address |
| req_bytes | output | LINE_BYTES | Byte enables within the line |
| req_lanes | output | LANES | Lanes served by this request |
| done | output | 1 | One-cycle pulse: all active lanes served |
| done_count | output | CNT_W | Requests produced by the finished instruction |
| done_uncoalesced | output | 1 | Finished instruction needed more than one request |

## Verification
The first request is on the outputs one cycle after the accepting edge, because the lane state is held in one register stage. Each later request appears one cycle after the previous handshake. done and its count follow one cycle after the final handshake, or one cycle after acceptance when the mask is all zero. The bench drives inputs and ready on the falling edge and samples one time unit later. It compares request k with the k-th entry of a line list computed arithmetically from the lane addresses and mask. Under random back-pressure it checks that a stalled request is still unchanged on the next falling edge, and it checks done at the falling edge right after the last handshake edge.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } coal_state_e;
endpackage

// File: rtl/coal_first_lane.sv
module coal_first_lane #(
  parameter int LANES = 32,
  parameter int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/coal_line_match.sv
module coal_line_match #(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int IDX_W      = $clog2(LANES)
) (
  input  logic [LANES*ADDR_W-1:0]               addr,
  input  logic [LANES-1:0]                      pending,
  input  logic [IDX_W-1:0]                      lead,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  lead_line,
  output logic [LANES-1:0]                      match
);
  localparam int LOG_LINE = $clog2(LINE_BYTES);
  localparam int LINE_W   = ADDR_W - LOG_LINE;

  assign lead_line = addr[int'(lead)*ADDR_W + LOG_LINE +: LINE_W];

  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign match[g] = pending[g] &&
                      (addr[g*ADDR_W + LOG_LINE +: LINE_W] == lead_line);
  end

  // Whenever lanes are pending, the leading lane must itself be in the set served.
  always_comb begin
    if (pending != '0) begin
      assert_leader_served_R4: assert (match[lead] == 1'b1);
    end
  end
endmodule

// File: rtl/coal_byte_mask.sv
module coal_byte_mask #(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 64,
  parameter int ACCESS_BYTES = 4
) (
  input  logic [LANES*ADDR_W-1:0] addr,
  input  logic [LANES-1:0]        lanes,
  output logic [LINE_BYTES-1:0]   bytes
);
  localparam int LOG_LINE = $clog2(LINE_BYTES);
  localparam logic [LINE_BYTES-1:0] UNIT =
    {{(LINE_BYTES-ACCESS_BYTES){1'b0}}, {ACCESS_BYTES{1'b1}}};

  logic [LINE_BYTES-1:0] lane_bytes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g] = lanes[g] ? (UNIT << addr[g*ADDR_W +: LOG_LINE])
                                    : '0;
  end

  always_comb begin
    bytes = '0;
    for (int i = 0; i < LANES; i++) bytes = bytes | lane_bytes[i];
  end

  always_comb begin
    if (lanes != '0) begin
      assert_bytes_nonempty_R5: assert (bytes != '0);
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 64,
  parameter int ACCESS_BYTES = 4,
  parameter int CNT_W        = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]        in_mask,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [ADDR_W-1:0]       req_base,
  output logic [LINE_BYTES-1:0]   req_bytes,
  output logic [LANES-1:0]        req_lanes,
  output logic                    done,
  output logic [CNT_W-1:0]        done_count,
  output logic                    done_uncoalesced
);
  localparam int LOG_LINE = $clog2(LINE_BYTES);
  localparam int LINE_W   = ADDR_W - LOG_LINE;
  localparam int IDX_W    = $clog2(LANES);

  coal_state_e             state_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        mask_q;
  logic [LANES-1:0]        pending_q;
  logic [CNT_W-1:0]        count_q;
  logic                    done_q;
  logic [CNT_W-1:0]        done_count_q;
  logic                    uncoal_q;

  logic [IDX_W-1:0]  lead_idx;
  logic              lead_any;
  logic [LINE_W-1:0] lead_line;
  logic [LANES-1:0]  match;
  logic [LANES-1:0]  pending_nx;
  logic              accept;
  logic              fire;

  coal_first_lane #(.LANES(LANES), .IDX_W(IDX_W)) u_first (
    .vec (pending_q),
    .idx (lead_idx),
    .any (lead_any)
  );

  coal_line_match #(
    .LANES(LANES), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W)
  ) u_match (
    .addr      (addr_q),
    .pending   (pending_q),
    .lead      (lead_idx),
    .lead_line (lead_line),
    .match     (match)
  );

  coal_byte_mask #(
    .LANES(LANES), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
    .ACCESS_BYTES(ACCESS_BYTES)
  ) u_bytes (
    .addr  (addr_q),
    .lanes (match),
    .bytes (req_bytes)
  );

  assign in_ready   = (state_q == ST_IDLE);
  assign accept     = in_valid && in_ready;
  assign req_valid  = (state_q == ST_EMIT) && lead_any;
  assign fire       = req_valid && req_ready;
  assign req_lanes  = match;
  assign req_base   = {lead_line, {LOG_LINE{1'b0}}};
  assign pending_nx = pending_q & ~match;

  assign done             = done_q;
  assign done_count       = done_count_q;
  assign done_uncoalesced = uncoal_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      mask_q       <= '0;
      pending_q    <= '0;
      count_q      <= '0;
      done_q       <= 1'b0;
      done_count_q <= '0;
      uncoal_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        addr_q    <= in_addr;
        mask_q    <= in_mask;
        pending_q <= in_mask;
        count_q   <= '0;
        if (in_mask == '0) begin
          done_q       <= 1'b1;
          done_count_q <= '0;
          uncoal_q     <= 1'b0;
        end else begin
          state_q <= ST_EMIT;
        end
      end
      if (fire) begin
        pending_q <= pending_nx;
        count_q   <= count_q + 1'b1;
        if (pending_nx == '0) begin
          state_q      <= ST_IDLE;
          done_q       <= 1'b1;
          done_count_q <= count_q + 1'b1;
          uncoal_q     <= (count_q != '0);
        end
      end
    end
  end

  // R6: a stalled request holds its contents until taken
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_base) &&
                                   $stable(req_lanes) && $stable(req_bytes)));

  // R3: only active lanes are ever served, and each request serves someone
  assert_lanes_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((req_lanes & ~mask_q) == '0) && (req_lanes != '0));

  // R7: completion coincides with the idle state
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (in_ready && !req_valid));

  // R7: a finished instruction never needs more requests than active lanes
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(done_count) <= $countones(mask_q)));

  // R8: the uncoalesced flag agrees with the reported count
  assert_uncoal_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_uncoalesced == (done_count > 1)));

  // R1: the block stops accepting while requests are outstanding
  assert_no_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !in_ready);
endmodule

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
  localparam int LANES = 8;
  localparam int AW    = 16;
  localparam int LB    = 64;
  localparam int AB    = 4;
  localparam int CW    = $clog2(LANES + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES*AW-1:0] in_addr = '0;
  logic [LANES-1:0] in_mask = '0;
  logic req_valid;
  logic req_ready = 1'b0;
  logic [AW-1:0] req_base;
  logic [LB-1:0] req_bytes;
  logic [LANES-1:0] req_lanes;
  logic done;
  logic [CW-1:0] done_count;
  logic done_uncoalesced;

  always #2 clk = ~clk;

  warp_coalescer #(.LANES(LANES), .ADDR_W(AW), .LINE_BYTES(LB),
                   .ACCESS_BYTES(AB), .CNT_W(CW)) u_warp_coalescer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_mask(in_mask), .req_valid(req_valid),
    .req_ready(req_ready), .req_base(req_base), .req_bytes(req_bytes),
    .req_lanes(req_lanes), .done(done), .done_count(done_count),
    .done_uncoalesced(done_uncoalesced));

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [AW-1:0] st_addr [LANES];
  logic [LANES-1:0] st_mask;
  logic [AW-1:0] ex_base [LANES];
  logic [LANES-1:0] ex_lanes [LANES];
  logic [LB-1:0] ex_bytes [LANES];
  int n_exp;

  task automatic chk(input bit ok, input string tag, input logic [63:0] got,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Expected request list derived from R2, R4, R5
  task automatic build_model();
    logic [LANES-1:0] pend;
    pend = st_mask;
    n_exp = 0;
    while (pend != '0) begin
      int lead;
      logic [AW-LOG2LB-1:0] line;
      lead = 0;
      for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
      line = st_addr[lead] >> LOG2LB;
      ex_lanes[n_exp] = '0;
      ex_bytes[n_exp] = '0;
      for (int i = 0; i < LANES; i++) begin
        if (pend[i] && ((st_addr[i] >> LOG2LB) == line)) begin
          ex_lanes[n_exp][i] = 1'b1;
          for (int b = 0; b < AB; b++) begin
            int pos;
            pos = int'(st_addr[i] % LB) + b;
            if (pos < LB) ex_bytes[n_exp][pos] = 1'b1;
          end
        end
      end
      ex_base[n_exp] = AW'(line) << LOG2LB;
      pend = pend & ~ex_lanes[n_exp];
      n_exp++;
    end
  endtask

  localparam int LOG2LB = $clog2(LB);

  task automatic run_instr(input bit bp);
    int k;
    int cyc;
    bit stalled;
    logic [AW-1:0] s_base;
    logic [LANES-1:0] s_lanes;
    logic [LB-1:0] s_bytes;
    build_model();
    @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R1 in_ready idle", 64'(in_ready), 64'd1);
    for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = st_addr[i];
    in_mask = st_mask;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (n_exp == 0) begin
      #1;
      chk(done == 1'b1, "R3 empty mask done", 64'(done), 64'd1);
      chk(done_count == 0, "R3 empty mask count", 64'(done_count), 64'd0);
      chk(req_valid == 1'b0, "R3 empty mask no request", 64'(req_valid), 64'd0);
      return;
    end
    k = 0;
    cyc = 0;
    stalled = 1'b0;
    while (k < n_exp && cyc < 400) begin
      if (bp) begin
        step_lfsr();
        req_ready = lfsr[0] | lfsr[3];
      end else begin
        req_ready = 1'b1;
      end
      #1;
      if (stalled) begin
        chk(req_valid && req_base == s_base && req_lanes == s_lanes &&
            req_bytes == s_bytes, "R6 stalled request held",
            64'(req_lanes), 64'(s_lanes));
      end
      if (!req_valid) begin
        chk(1'b0, "R4 request missing", 64'(req_valid), 64'd1);
        k = n_exp;
      end else if (req_ready) begin
        chk(req_base == ex_base[k], "R2 req_base", 64'(req_base), 64'(ex_base[k]));
        chk(req_lanes == ex_lanes[k], "R4 req_lanes", 64'(req_lanes),
            64'(ex_lanes[k]));
        chk(req_bytes == ex_bytes[k], "R5 req_bytes", 64'(req_bytes),
            64'(ex_bytes[k]));
        chk((req_lanes & ~st_mask) == '0, "R3 inactive lane served",
            64'(req_lanes), 64'(st_mask));
        k++;
        stalled = 1'b0;
      end else begin
        s_base = req_base;
        s_lanes = req_lanes;
        s_bytes = req_bytes;
        stalled = 1'b1;
      end
      @(negedge clk);
      cyc++;
    end
    req_ready = 1'b0;
    #1;
    chk(done == 1'b1, "R7 done after final handshake", 64'(done), 64'd1);
    chk(int'(done_count) == n_exp, "R7 done_count", 64'(done_count), 64'(n_exp));
    chk(done_uncoalesced == (n_exp > 1), "R8 uncoalesced flag",
        64'(done_uncoalesced), 64'(n_exp > 1));
    chk(in_ready == 1'b1, "R7 in_ready with done", 64'(in_ready), 64'd1);
    chk(req_valid == 1'b0, "R7 no request after done", 64'(req_valid), 64'd0);
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R7 done one cycle", 64'(done), 64'd0);
  endtask

  bit finished = 1'b0;

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got %0d expected %0d", 0, 1);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int strides [8] = '{0, 4, 8, 16, 32, 64, 128, 256};
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b1 && req_valid == 1'b0 && done == 1'b0,
        "R1 reset state", {61'd0, in_ready, req_valid, done}, 64'h4);
    rst_n = 1'b1;

    // R9: fully consecutive 4-byte pattern from 0x0
    for (int i = 0; i < LANES; i++) st_addr[i] = AW'(i * 4);
    st_mask = '1;
    run_instr(1'b0);
    chk(n_exp == 1 && ex_base[0] == 0 && ex_bytes[0] == 64'hFFFF_FFFF,
        "R9 consecutive collapses to one line", 64'(ex_bytes[0]),
        64'hFFFF_FFFF);

    // R3: all lanes masked off
    st_mask = '0;
    run_instr(1'b0);

    // Stride and start sweep, alternating full and random masks
    for (int s = 0; s < 8; s++) begin
      for (int st = 0; st < LB; st += 4) begin
        for (int i = 0; i < LANES; i++) st_addr[i] = AW'(st + i * strides[s]);
        step_lfsr();
        st_mask = ((st / 4) % 2 == 0) ? '1 : lfsr[LANES-1:0];
        run_instr(s[0]);
      end
    end

    // Scattered addresses in a small window with back-pressure
    for (int t = 0; t < 200; t++) begin
      for (int i = 0; i < LANES; i++) begin
        step_lfsr();
        st_addr[i] = AW'({lfsr[6:0], 2'b00});
      end
      step_lfsr();
      st_mask = (t % 17 == 0) ? '0 : lfsr[LANES-1:0] | lfsr[LANES+3:4];
      run_instr(1'b1);
    end

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule